// File: doc/BRIEF.md
# Reconfigurable Four-Core Systolic Multiply-Accumulate Array

This block is a grid of four small input-stationary systolic cores. Core 0 sits top-left, core 1 top-right, core 2 bottom-left and core 3 bottom-right. Each core holds `R` rows by `C` columns of integer multiply-accumulate elements. Each element keeps one stationary operand. A streaming operand moves right from element to element, and a partial sum moves down. Two-input multiplexers on the links between cores let one mode input select how the cores work together: as one large array, as two column pairs, as two row pairs, or as four separate cores. Small edge tiles can then keep most elements busy, and large tiles still reuse operands across the whole grid.

A wave runs as a fixed sequence of states: `ST_IDLE`, `ST_LOAD`, `ST_STREAM`, `ST_DRAIN`, then back to `ST_IDLE`. A `go` pulse in `ST_IDLE` latches the mode and the wave length. This is transition idle-to-load. `ST_LOAD` lasts `R` cycles and shifts stationary rows down into every core (load-to-stream). `ST_STREAM` lasts one cycle per streaming vector (stream-to-drain). The block skews each row internally by one cycle per row index. `ST_DRAIN` lasts `2R+2C` cycles while the last sums leave the bottom edge (drain-to-idle). Results leave the array with a matching skew. Each column has its own valid flag.

Top module: `fsa_quad`

## Requirements
- R1: After reset, `busy` and `mode_err` are 0, and no bit of `res_main_vld` or `res_side_vld` is set.
- R2: The mode encoding is 0 whole array, 1 column pairs, 2 row pairs, 3 separate cores. Mode 0 behaves as follows:
  - every core takes stationary data from its own slice of `pl_data`;
  - the left port feeds every row through both core columns;
  - upper sums flow into cores 2 and 3;
  - `res_main` column j gives the sum over all `2R` rows of stream times weight;
  - `res_side_vld` stays 0.
- R3: Mode 1 behaves as follows:
  - cores 1 and 3 load the stationary data of cores 0 and 2;
  - cores 1 and 3 stream from `xr_data` instead of the left chain;
  - sums still chain top to bottom;
  - `res_side_vld` stays 0.
- R4: Mode 2 behaves as follows:
  - cores 2 and 3 load the stationary data of cores 0 and 1;
  - the left port streams through both cores of each row;
  - cores 2 and 3 start from a zero partial sum;
  - `res_main` carries the lower-core sums;
  - `res_side` carries the upper-core sums, with valid set.
- R5: Mode 3 routes stationary data as in mode 2 and splits the outputs as in mode 2. Cores 1 and 3 stream from `xr_data`.
- R6: `pl_data` packs core k, local column c at bits `(k*C+c)*DW`. The word presented on load cycle n (n = 0 to R-1) ends up in local row `R-1-n` of the core that takes it.
- R7: `go` is accepted only in `ST_IDLE`. A `go` during a wave changes neither the current wave nor its length.
- R8: The mode is latched at an accepted `go`. If the mode input differs from the latched mode while busy, `mode_err` sets one cycle later. The running wave still follows the latched mode. `mode_err` stays set until the next accepted `go` clears it.
- R9: For a wave of L vectors (`wave_len` 0 counts as 1):
  - `busy` is high for exactly `R+L+2R+2C` cycles;
  - each active output column gives exactly L valid results in stream order;
  - no result is valid while `busy` is low.
- R10: Row i of `xl_data` and `xr_data` sits at bits `i*DW`. Output column j of `res_main` and `res_side` sits at bits `j*AW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go | input | 1 | Starts a wave when idle |
| mode | input | 2 | Core grouping select |
| wave_len | input | LW | Number of streaming vectors |
| pl_data | input | 4*C*DW | Stationary rows, one slice per core |
| xl_data | input | 2*R*DW | Left streaming vector |
| xr_data | input | 2*R*DW | Right-half streaming vector |
| busy | output | 1 | Wave in progress |
| mode_err | output | 1 | Mode input moved during a wave |
| res_main | output | 2*C*AW | Sums below cores 2 and 3 |
| res_main_vld | output | 2*C | Per-column valid for res_main |
| res_side | output | 2*C*AW | Upper-core sums on the added vertical path |
| res_side_vld | output | 2*C | Per-column valid for res_side |

## Verification
Faults in the cross-core multiplexers or in stationary routing corrupt particular output columns. A wrong stationary copy or a wrong stream source shows up in one core column. A wrong partial-sum link shows up as main and side values being swapped or added together. These errors appear in the first valid result of the first wave in the affected mode. A fault in the state machine's counters changes the length of `busy` or the number of results per column. This is seen when that wave ends.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
    typedef enum logic [1:0] {
        MD_WHOLE   = 2'd0,
        MD_COLPAIR = 2'd1,
        MD_ROWPAIR = 2'd2,
        MD_SPLIT   = 2'd3
    } fsa_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STREAM,
        ST_DRAIN
    } fsa_state_e;
endpackage

// File: rtl/fsa_pe.sv
module fsa_pe #(
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [DW-1:0] w_in,
    input  logic [DW-1:0] a_in,
    input  logic          av_in,
    input  logic [AW-1:0] ps_in,
    output logic [DW-1:0] w_q,
    output logic [DW-1:0] a_q,
    output logic          av_q,
    output logic [AW-1:0] ps_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q  <= '0;
            a_q  <= '0;
            av_q <= 1'b0;
            ps_q <= '0;
        end else begin
            if (ld_en) w_q <= w_in;
            a_q  <= a_in;
            av_q <= av_in;
            ps_q <= ps_in + AW'(a_in) * AW'(w_q);
        end
    end
endmodule

// File: rtl/fsa_ctrl.sv
module fsa_ctrl import fsa_pkg::*; #(
    parameter int R  = 2,
    parameter int C  = 2,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [1:0]    mode_in,
    input  logic [LW-1:0] wave_len,
    output logic          busy,
    output logic          ld_en,
    output logic          st_en,
    output fsa_mode_e     mode_q,
    output logic          mode_err
);
    localparam logic [LW-1:0] LOAD_LAST  = LW'(R - 1);
    localparam logic [LW-1:0] DRAIN_LAST = LW'(2*R + 2*C - 1);

    fsa_state_e    state;
    logic [LW-1:0] cnt;
    logic [LW-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            len_q    <= '0;
            mode_q   <= MD_WHOLE;
            mode_err <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (go) begin
                    state    <= ST_LOAD;
                    cnt      <= '0;
                    mode_q   <= fsa_mode_e'(mode_in);
                    len_q    <= (wave_len == '0) ? LW'(1) : wave_len;
                    mode_err <= 1'b0;
                end
                ST_LOAD: if (cnt == LOAD_LAST) begin
                    state <= ST_STREAM;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                ST_STREAM: if (cnt == len_q - 1'b1) begin
                    state <= ST_DRAIN;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                ST_DRAIN: if (cnt == DRAIN_LAST) begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
            endcase
            if (state != ST_IDLE && mode_in != mode_q) mode_err <= 1'b1;
        end
    end

    always_comb begin
        busy  = (state != ST_IDLE);
        ld_en = (state == ST_LOAD);
        st_en = (state == ST_STREAM);
    end

    AST_GO_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && go) |=> (state == ST_LOAD)); // R7
    AST_BUSY_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && go) |=> $stable(len_q)); // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q)); // R8
    AST_LOAD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && cnt == LOAD_LAST) |=> (state == ST_STREAM)); // R6
endmodule

// File: rtl/fsa_quad.sv
module fsa_quad import fsa_pkg::*; #(
    parameter int R  = 2,
    parameter int C  = 2,
    parameter int DW = 8,
    parameter int AW = 32,
    parameter int LW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [1:0]        mode,
    input  logic [LW-1:0]     wave_len,
    input  logic [4*C*DW-1:0] pl_data,
    input  logic [2*R*DW-1:0] xl_data,
    input  logic [2*R*DW-1:0] xr_data,
    output logic              busy,
    output logic              mode_err,
    output logic [2*C*AW-1:0] res_main,
    output logic [2*C-1:0]    res_main_vld,
    output logic [2*C*AW-1:0] res_side,
    output logic [2*C-1:0]    res_side_vld
);
    localparam int NR = 2 * R;
    localparam int NC = 2 * C;

    fsa_mode_e mode_q;
    logic      ld_en, st_en;
    logic      use_right, chain_pairs;

    fsa_ctrl #(.R(R), .C(C), .LW(LW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .mode_in(mode), .wave_len(wave_len),
        .busy(busy), .ld_en(ld_en), .st_en(st_en), .mode_q(mode_q), .mode_err(mode_err)
    );

    always_comb begin
        use_right   = (mode_q == MD_COLPAIR) || (mode_q == MD_SPLIT);
        chain_pairs = (mode_q == MD_WHOLE)   || (mode_q == MD_COLPAIR);
    end

    logic [DW-1:0] row_l [NR];
    logic [DW-1:0] row_r [NR];
    logic          row_v [NR];

    for (genvar gi = 0; gi < NR; gi++) begin : g_skew
        if (gi == 0) begin : g_direct
            assign row_l[gi] = st_en ? xl_data[gi*DW +: DW] : '0;
            assign row_r[gi] = st_en ? xr_data[gi*DW +: DW] : '0;
            assign row_v[gi] = st_en;
        end else begin : g_delay
            logic [DW-1:0] sl [gi];
            logic [DW-1:0] sr [gi];
            logic          sv [gi];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int k = 0; k < gi; k++) begin
                        sl[k] <= '0;
                        sr[k] <= '0;
                        sv[k] <= 1'b0;
                    end
                end else begin
                    sl[0] <= st_en ? xl_data[gi*DW +: DW] : '0;
                    sr[0] <= st_en ? xr_data[gi*DW +: DW] : '0;
                    sv[0] <= st_en;
                    for (int k = 1; k < gi; k++) begin
                        sl[k] <= sl[k-1];
                        sr[k] <= sr[k-1];
                        sv[k] <= sv[k-1];
                    end
                end
            end
            assign row_l[gi] = sl[gi-1];
            assign row_r[gi] = sr[gi-1];
            assign row_v[gi] = sv[gi-1];
        end
    end

    logic [DW-1:0] w_q  [NR][NC];
    logic [DW-1:0] a_q  [NR][NC];
    logic          av_q [NR][NC];
    logic [AW-1:0] ps_q [NR][NC];

    for (genvar gi = 0; gi < NR; gi++) begin : g_row
        for (genvar gj = 0; gj < NC; gj++) begin : g_col
            localparam int CR   = gi / R;
            localparam int CC   = gj / C;
            localparam int CI   = CR * 2 + CC;
            localparam int CCOL = gj % C;
            logic [DW-1:0] w_in, a_in;
            logic          av_in;
            logic [AW-1:0] ps_in;

            if (gi % R == 0) begin : g_wtop
                logic [1:0] src;
                always_comb begin
                    unique case (mode_q)
                        MD_WHOLE:   src = 2'(CI);
                        MD_COLPAIR: src = 2'(CR * 2);
                        default:    src = 2'(CC);
                    endcase
                end
                assign w_in = pl_data[(int'(src) * C + CCOL) * DW +: DW];
            end else begin : g_wchain
                assign w_in = w_q[gi-1][gj];
            end

            if (gj == 0) begin : g_aleft
                assign a_in  = row_l[gi];
                assign av_in = row_v[gi];
            end else if (gj == C) begin : g_amux
                assign a_in  = use_right ? row_r[gi] : a_q[gi][gj-1];
                assign av_in = use_right ? row_v[gi] : av_q[gi][gj-1];
            end else begin : g_achain
                assign a_in  = a_q[gi][gj-1];
                assign av_in = av_q[gi][gj-1];
            end

            if (gi == 0) begin : g_ptop
                assign ps_in = '0;
            end else if (gi == R) begin : g_pmux
                assign ps_in = chain_pairs ? ps_q[gi-1][gj] : '0;
            end else begin : g_pchain
                assign ps_in = ps_q[gi-1][gj];
            end

            fsa_pe #(.DW(DW), .AW(AW)) u_pe (
                .clk(clk), .rst_n(rst_n), .ld_en(ld_en),
                .w_in(w_in), .a_in(a_in), .av_in(av_in), .ps_in(ps_in),
                .w_q(w_q[gi][gj]), .a_q(a_q[gi][gj]), .av_q(av_q[gi][gj]), .ps_q(ps_q[gi][gj])
            );
        end
    end

    for (genvar gj = 0; gj < NC; gj++) begin : g_out
        assign res_main[gj*AW +: AW] = ps_q[NR-1][gj];
        assign res_main_vld[gj]      = av_q[NR-1][gj];
        assign res_side[gj*AW +: AW] = ps_q[R-1][gj];
        assign res_side_vld[gj]      = av_q[R-1][gj] & ~chain_pairs;
    end

    AST_VLD_IN_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|res_main_vld) |-> busy); // R9
    AST_SIDE_IN_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|res_side_vld) |-> (busy && !chain_pairs)); // R4
endmodule

// File: tb/test_fsa_quad.sv
`timescale 1ns/1ps
module test_fsa_quad;
    localparam int R = 2, C = 2, DW = 8, AW = 32, LW = 8;
    localparam int NR = 2*R, NC = 2*C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              go = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic [LW-1:0]     wave_len = '0;
    logic [4*C*DW-1:0] pl_data = '0;
    logic [NR*DW-1:0]  xl_data = '0;
    logic [NR*DW-1:0]  xr_data = '0;
    logic              busy, mode_err;
    logic [NC*AW-1:0]  res_main, res_side;
    logic [NC-1:0]     res_main_vld, res_side_vld;

    always #2 clk = ~clk;

    fsa_quad #(.R(R), .C(C), .DW(DW), .AW(AW), .LW(LW)) i_fsa_quad (
        .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .wave_len(wave_len),
        .pl_data(pl_data), .xl_data(xl_data), .xr_data(xr_data),
        .busy(busy), .mode_err(mode_err),
        .res_main(res_main), .res_main_vld(res_main_vld),
        .res_side(res_side), .res_side_vld(res_side_vld)
    );

    int nchk = 0, nfail = 0, busy_cyc = 0;
    string cur_tag = "R2";
    int pw [4][R][C];
    int xl [16][NR];
    int xr [16][NR];
    logic [AW-1:0] qm [NC][$];
    logic [AW-1:0] qs [NC][$];

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // Scoreboard monitor: pops one expected value per valid column (R9, R10 column packing)
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cyc++;
            for (int j = 0; j < NC; j++) begin
                if (res_main_vld[j]) begin
                    if (qm[j].size() == 0) chk("R9", $sformatf("extra main col%0d", j), 1, 0);
                    else chk(cur_tag, $sformatf("main col%0d", j), res_main[j*AW +: AW], qm[j].pop_front());
                end
                if (res_side_vld[j]) begin
                    if (qs[j].size() == 0) chk(cur_tag, $sformatf("extra side col%0d", j), 1, 0);
                    else chk(cur_tag, $sformatf("side col%0d", j), res_side[j*AW +: AW], qs[j].pop_front());
                end
            end
        end
    end

    task automatic run_wave(input int m, input int len, input bit chg, input bit xgo);
        int cc, c, ci, s, wv, xv, up, lo;
        cur_tag = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
        for (int k = 0; k < 4; k++)
            for (int r = 0; r < R; r++)
                for (int q = 0; q < C; q++) pw[k][r][q] = $urandom % 16;
        for (int t = 0; t < len; t++)
            for (int i = 0; i < NR; i++) begin
                xl[t][i] = $urandom % 16;
                xr[t][i] = $urandom % 16;
            end
        // Expected sums from the mode rules (R2..R5); ordering of preload rows from R6
        for (int t = 0; t < len; t++)
            for (int j = 0; j < NC; j++) begin
                cc = j / C; c = j % C; up = 0; lo = 0;
                for (int i = 0; i < NR; i++) begin
                    ci = (i / R) * 2 + cc;
                    s  = (m == 0) ? ci : (m == 1) ? (i / R) * 2 : cc;
                    wv = pw[s][i % R][c];
                    xv = (cc == 1 && (m == 1 || m == 3)) ? xr[t][i] : xl[t][i];
                    if (i < R) up += xv * wv; else lo += xv * wv;
                end
                if (m <= 1) qm[j].push_back(AW'(up + lo));
                else begin
                    qm[j].push_back(AW'(lo));
                    qs[j].push_back(AW'(up));
                end
            end
        @(negedge clk);
        busy_cyc = 0;
        go = 1'b1; mode = 2'(m); wave_len = LW'(len);
        for (int k = 0; k < R; k++) begin
            @(negedge clk);
            go = 1'b0;
            for (int s2 = 0; s2 < 4; s2++)
                for (int q = 0; q < C; q++) pl_data[(s2*C+q)*DW +: DW] = DW'(pw[s2][R-1-k][q]);
        end
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            pl_data = '0;
            for (int i = 0; i < NR; i++) begin
                xl_data[i*DW +: DW] = DW'(xl[t][i]);
                xr_data[i*DW +: DW] = DW'(xr[t][i]);
            end
            go = xgo && (t == 0);
            if (xgo && t == 0) wave_len = LW'(len + 3);
            if (chg && t == 0) mode = 2'(m ^ 1);
        end
        @(negedge clk);
        go = 1'b0; xl_data = '0; xr_data = '0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(xgo ? "R7" : "R9", "busy cycles", busy_cyc, R + len + 2*R + 2*C);
        for (int j = 0; j < NC; j++) begin
            chk("R9", $sformatf("main left col%0d", j), qm[j].size(), 0);
            chk(cur_tag, $sformatf("side left col%0d", j), qs[j].size(), 0);
            qm[j].delete();
            qs[j].delete();
        end
        chk("R8", "mode_err", mode_err, chg ? 1 : 0);
        mode = 2'(m);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "mode_err", mode_err, 0);
        chk("R1", "main vld", res_main_vld, 0);
        chk("R1", "side vld", res_side_vld, 0);
        run_wave(0, 5, 1'b0, 1'b0);  // R2 whole array
        run_wave(1, 4, 1'b0, 1'b0);  // R3 column pairs
        run_wave(2, 6, 1'b0, 1'b0);  // R4 row pairs
        run_wave(3, 3, 1'b0, 1'b0);  // R5 separate cores
        run_wave(0, 4, 1'b1, 1'b0);  // R8 mode moved mid-wave
        run_wave(1, 3, 1'b0, 1'b0);  // R8 flag cleared by next go
        run_wave(2, 4, 1'b0, 1'b1);  // R7 go while busy
        run_wave(0, 1, 1'b0, 1'b0);  // R9 single vector
        run_wave(3, 8, 1'b0, 1'b0);  // R5 longer wave
        run_wave(3, 2, 1'b1, 1'b0);  // R8 in split mode
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R9 watchdog act=running exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule